// File: doc/BRIEF.md
# Radix-4 In-Place FFT Engine

This block computes a 16-point complex discrete Fourier transform in a single working memory. It uses one radix-4 butterfly unit, and that unit runs once for every group of four points. Software-side logic first writes sixteen samples, each with a 16-bit real part and a 16-bit imaginary part, through a load port. It then pulses `start`. A controller runs two decimation-in-frequency passes of four butterflies each. For each butterfly it fetches four points one after another, forms the 4-point transform, applies the twiddle rotation, and writes the four results back to the addresses they came from. The multiplication by -j inside the butterfly is a swap of the real and imaginary parts with one negation, so the butterfly itself has no multiplier. Only the twiddle rotation multiplies, and its coefficients are 18-bit constants held in a register bank that reset loads.

Each pass divides by four with an arithmetic right shift, so a full run gives the transform scaled by 1/16. Twiddle products are rounded to nearest and then saturated to 16 bits. The in-place passes leave the spectrum in base-4 digit-reversed order. The readout port reverses the digits of the address it is given, so the caller reads bins in natural frequency order. While the run is in progress `busy` is high. A low `ce` freezes the controller. At the end, a single-cycle `finish` appears in the same cycle that `busy` falls.

Top module: `fft4_engine`

## Requirements
- R1: While `rst` is high, and in the first cycle after it is released, `busy` and `finish` are both 0.
- R2: A `start` sampled high with `ce` high while the engine is idle sets `busy` from the next cycle. `busy` then stays high for exactly 80 cycles in which `ce` is high. It is followed by one cycle with `finish` = 1 and `busy` = 0, and after that `finish` returns to 0.
- R3: After a run, setting `rd_addr` = f gives, one cycle later, bin f of the 16-point forward DFT of the loaded samples divided by 16 on `rd_re`/`rd_im`. Bin f is sum over n of x[n]·exp(-j·2π·f·n/16). The result is within 4 LSB when no input component exceeds 12000 in magnitude.
- R4: When all 16 samples equal the same value (A, B), the result is exactly (A, B) in bin 0 and exactly (0, 0) in every other bin.
- R5: For an impulse (A, B) at index 0 with all other samples zero, every bin reads exactly (floor(floor(A/4)/4), floor(floor(B/4)/4)).
- R6: While `ce` is low during a run, the controller holds its state. `busy` stays high, `finish` is delayed by exactly the number of low-`ce` cycles, and the results are the same as in an uninterrupted run.
- R7: A `start` pulse while `busy` is high is ignored. This holds even in the last busy cycle. The run length does not change and no second run follows.
- R8: A write on the load port (`ld_en` = 1) while `busy` is high is ignored and does not alter the results.
- R9: A `start` sampled while `ce` is low and the engine is idle does not begin a run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ce | input | 1 | Chip enable; low freezes the controller |
| start | input | 1 | Begin a transform when idle |
| busy | output | 1 | High while the passes run |
| finish | output | 1 | One-cycle completion pulse |
| ld_en | input | 1 | Write one sample (ignored while busy) |
| ld_addr | input | 4 | Sample index n, natural order |
| ld_re | input | 16 | Real part of the sample, signed |
| ld_im | input | 16 | Imaginary part of the sample, signed |
| rd_addr | input | 4 | Frequency bin f to read, natural order |
| rd_re | output | 16 | Real part of the bin, signed, one cycle after `rd_addr` |
| rd_im | output | 16 | Imaginary part of the bin, signed, one cycle after `rd_addr` |

## Verification
`busy` is due one cycle after the edge that accepts `start`, and `finish` is due 81 cycles after that edge plus one cycle for every cycle with `ce` low. The bench counts cycles from the accepting edge, sampling on falling edges. It compares the count at which `finish` is first seen with that figure, and it checks `finish` and `busy` again one cycle later. A bin is due one cycle after its address is applied. The driver puts each address on a falling edge and queues the bin expected from a DFT computed in the bench, and the monitor compares it with `rd_re`/`rd_im` on the next falling edge. Constant and impulse inputs are compared exactly, and tones and pseudo-random data within 4 LSB.

// File: rtl/fft4_pkg.sv
`timescale 1ns/1ps
package fft4_pkg;

  localparam int FFT_N   = 16;
  localparam int DIG     = 2;                 // bits per base-4 digit
  localparam int AW      = 2 * DIG;           // address width
  localparam int PTS     = 2 ** DIG;          // points per butterfly
  localparam int BF_PASS = FFT_N / PTS;       // butterflies per pass
  localparam int PASSES  = AW / DIG;          // radix-4 passes
  localparam int BF_CYC  = 2 * PTS + 2;       // read, wait, calc, write
  localparam int RUN_STEPS = PASSES * BF_PASS * BF_CYC;

  typedef enum logic [2:0] {
    S_IDLE,
    S_RD,
    S_WAIT,
    S_CALC,
    S_WR
  } ctrl_state_t;

  // cos(2*pi*m/16) scaled by 2^16
  function automatic int cos_q16(int m);
    case (m % FFT_N)
      0:  return 65536;
      1:  return 60547;
      2:  return 46341;
      3:  return 25080;
      4:  return 0;
      5:  return -25080;
      6:  return -46341;
      7:  return -60547;
      8:  return -65536;
      9:  return -60547;
      10: return -46341;
      11: return -25080;
      12: return 0;
      13: return 25080;
      14: return 46341;
      default: return 60547;
    endcase
  endfunction

  function automatic logic [AW-1:0] digit_rev(logic [AW-1:0] a);
    return {a[DIG-1:0], a[AW-1:DIG]};
  endfunction

endpackage

// File: rtl/fft4_mem.sv
`timescale 1ns/1ps
module fft4_mem #(
  parameter int WD = 32,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [WD-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [WD-1:0] rdata
);
  localparam int DEPTH = 2 ** AW;

  logic [WD-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/fft4_twiddle.sv
`timescale 1ns/1ps
module fft4_twiddle #(
  parameter int TW = 18
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [fft4_pkg::AW-1:0] idx  [fft4_pkg::PTS],
  output logic signed [TW-1:0] w_re [fft4_pkg::PTS],
  output logic signed [TW-1:0] w_im [fft4_pkg::PTS]
);
  import fft4_pkg::*;

  localparam int SCALE = 2 ** (TW - 18);

  logic signed [TW-1:0] tw_re_q [FFT_N];
  logic signed [TW-1:0] tw_im_q [FFT_N];

  // coefficient bank loaded by reset; W^m = cos - j*sin
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < FFT_N; i++) begin
        tw_re_q[i] <= TW'(cos_q16(i) * SCALE);
        tw_im_q[i] <= TW'(cos_q16(i + 4) * SCALE);
      end
    end
  end

  for (genvar g = 0; g < PTS; g++) begin : g_rd
    assign w_re[g] = tw_re_q[idx[g]];
    assign w_im[g] = tw_im_q[idx[g]];
  end
endmodule

// File: rtl/fft4_bfly.sv
`timescale 1ns/1ps
module fft4_bfly #(
  parameter int DW = 16,
  parameter int TW = 18
) (
  input  logic signed [DW-1:0] a_re [fft4_pkg::PTS],
  input  logic signed [DW-1:0] a_im [fft4_pkg::PTS],
  input  logic signed [TW-1:0] w_re [fft4_pkg::PTS],
  input  logic signed [TW-1:0] w_im [fft4_pkg::PTS],
  output logic signed [DW-1:0] y_re [fft4_pkg::PTS],
  output logic signed [DW-1:0] y_im [fft4_pkg::PTS]
);
  import fft4_pkg::*;

  localparam int EW   = DW + 2;
  localparam int PW   = DW + TW + 1;
  localparam int FRAC = TW - 2;
  localparam logic signed [PW-1:0] HALF = PW'(2 ** (FRAC - 1));
  localparam logic signed [PW-1:0] VMAX = PW'((2 ** (DW - 1)) - 1);
  localparam logic signed [PW-1:0] VMIN = ~VMAX;

  function automatic logic signed [DW-1:0] sat(logic signed [PW-1:0] v);
    if (v > VMAX)      return {1'b0, {(DW-1){1'b1}}};
    else if (v < VMIN) return {1'b1, {(DW-1){1'b0}}};
    else               return v[DW-1:0];
  endfunction

  logic signed [EW-1:0] e_re [PTS];
  logic signed [EW-1:0] e_im [PTS];
  logic signed [EW-1:0] s_re [PTS];
  logic signed [EW-1:0] s_im [PTS];

  always_comb begin
    for (int i = 0; i < PTS; i++) begin
      e_re[i] = a_re[i];
      e_im[i] = a_im[i];
    end
  end

  // 4-point transform; -j*(x+jy) = y - jx, done by swap and negate
  always_comb begin
    s_re[0] = e_re[0] + e_re[1] + e_re[2] + e_re[3];
    s_im[0] = e_im[0] + e_im[1] + e_im[2] + e_im[3];
    s_re[1] = e_re[0] + e_im[1] - e_re[2] - e_im[3];
    s_im[1] = e_im[0] - e_re[1] - e_im[2] + e_re[3];
    s_re[2] = e_re[0] - e_re[1] + e_re[2] - e_re[3];
    s_im[2] = e_im[0] - e_im[1] + e_im[2] - e_im[3];
    s_re[3] = e_re[0] - e_im[1] - e_re[2] + e_im[3];
    s_im[3] = e_im[0] + e_re[1] - e_im[2] - e_re[3];
  end

  for (genvar n = 0; n < PTS; n++) begin : g_rot
    logic signed [DW-1:0] q_re, q_im;
    logic signed [PW-1:0] xr, xi, cr, ci, pr, pi, rr, ri;

    assign q_re = DW'(s_re[n] >>> 2);
    assign q_im = DW'(s_im[n] >>> 2);

    always_comb begin
      xr = q_re;
      xi = q_im;
      cr = w_re[n];
      ci = w_im[n];
      pr = xr * cr - xi * ci + HALF;
      pi = xr * ci + xi * cr + HALF;
      rr = pr >>> FRAC;
      ri = pi >>> FRAC;
    end

    assign y_re[n] = sat(rr);
    assign y_im[n] = sat(ri);
  end
endmodule

// File: rtl/fft4_ctrl.sv
`timescale 1ns/1ps
module fft4_ctrl (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       ce,
  input  logic                       start,
  output logic                       busy,
  output logic                       finish,
  output logic [fft4_pkg::AW-1:0]    eng_addr,
  output logic                       eng_wr,
  output logic [fft4_pkg::DIG-1:0]   pt_idx,
  output logic                       cap_en,
  output logic [fft4_pkg::DIG-1:0]   cap_idx,
  output logic                       calc_en,
  output logic                       pass,
  output logic [fft4_pkg::DIG-1:0]   bidx
);
  import fft4_pkg::*;

  localparam logic [DIG-1:0] LAST = DIG'(PTS - 1);
  localparam logic [DIG-1:0] LAST_BF = DIG'(BF_PASS - 1);

  ctrl_state_t    st;
  logic [DIG-1:0] cnt, bidx_q, capi_q;
  logic           pass_q, busy_q, fin_q, capv_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= S_IDLE;
      cnt    <= '0;
      bidx_q <= '0;
      pass_q <= 1'b0;
      busy_q <= 1'b0;
      fin_q  <= 1'b0;
      capv_q <= 1'b0;
      capi_q <= '0;
    end else begin
      fin_q <= 1'b0;
      if (ce) begin
        capv_q <= (st == S_RD);
        capi_q <= cnt;
        case (st)
          S_IDLE: if (start) begin
            st     <= S_RD;
            cnt    <= '0;
            bidx_q <= '0;
            pass_q <= 1'b0;
            busy_q <= 1'b1;
          end
          S_RD: begin
            cnt <= cnt + 1'b1;
            if (cnt == LAST) st <= S_WAIT;
          end
          S_WAIT: st <= S_CALC;
          S_CALC: st <= S_WR;
          S_WR: begin
            cnt <= cnt + 1'b1;
            if (cnt == LAST) begin
              if (bidx_q == LAST_BF) begin
                bidx_q <= '0;
                if (pass_q) begin
                  st     <= S_IDLE;
                  busy_q <= 1'b0;
                  fin_q  <= 1'b1;
                end else begin
                  pass_q <= 1'b1;
                  st     <= S_RD;
                end
              end else begin
                bidx_q <= bidx_q + 1'b1;
                st     <= S_RD;
              end
            end
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  // pass 0 strides by 4 (point index is the high digit), pass 1 is contiguous
  assign eng_addr = pass_q ? {bidx_q, cnt} : {cnt, bidx_q};
  assign eng_wr   = (st == S_WR) && ce;
  assign pt_idx   = cnt;
  assign cap_en   = capv_q && ce;
  assign cap_idx  = capi_q;
  assign calc_en  = (st == S_CALC) && ce;
  assign pass     = pass_q;
  assign bidx     = bidx_q;
  assign busy     = busy_q;
  assign finish   = fin_q;
endmodule

// File: rtl/fft4_engine.sv
`timescale 1ns/1ps
module fft4_engine #(
  parameter int DW = 16,
  parameter int TW = 18
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          ce,
  input  logic                          start,
  output logic                          busy,
  output logic                          finish,
  input  logic                          ld_en,
  input  logic [fft4_pkg::AW-1:0]       ld_addr,
  input  logic signed [DW-1:0]          ld_re,
  input  logic signed [DW-1:0]          ld_im,
  input  logic [fft4_pkg::AW-1:0]       rd_addr,
  output logic signed [DW-1:0]          rd_re,
  output logic signed [DW-1:0]          rd_im
);
  import fft4_pkg::*;

  localparam int WD = 2 * DW;

  logic [AW-1:0]  eng_addr;
  logic           eng_wr, cap_en, calc_en, pass;
  logic [DIG-1:0] pt_idx, cap_idx, bidx;

  logic           mem_we, mem_re;
  logic [AW-1:0]  mem_wa, mem_ra;
  logic [WD-1:0]  mem_wd, mem_q;

  logic signed [DW-1:0] cap_re [PTS];
  logic signed [DW-1:0] cap_im [PTS];
  logic signed [DW-1:0] bf_re  [PTS];
  logic signed [DW-1:0] bf_im  [PTS];
  logic signed [DW-1:0] res_re [PTS];
  logic signed [DW-1:0] res_im [PTS];
  logic signed [TW-1:0] w_re   [PTS];
  logic signed [TW-1:0] w_im   [PTS];
  logic [AW-1:0]        tw_idx [PTS];

  fft4_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .ce       (ce),
    .start    (start),
    .busy     (busy),
    .finish   (finish),
    .eng_addr (eng_addr),
    .eng_wr   (eng_wr),
    .pt_idx   (pt_idx),
    .cap_en   (cap_en),
    .cap_idx  (cap_idx),
    .calc_en  (calc_en),
    .pass     (pass),
    .bidx     (bidx)
  );

  // the engine owns the memory while busy; ports own it otherwise
  assign mem_we = busy ? eng_wr   : ld_en;
  assign mem_wa = busy ? eng_addr : ld_addr;
  assign mem_wd = busy ? {res_re[pt_idx], res_im[pt_idx]} : {ld_re, ld_im};
  assign mem_ra = busy ? eng_addr : digit_rev(rd_addr);
  assign mem_re = !busy || ce;

  fft4_mem #(.WD(WD), .AW(AW)) u_mem (
    .clk   (clk),
    .we    (mem_we),
    .waddr (mem_wa),
    .wdata (mem_wd),
    .re    (mem_re),
    .raddr (mem_ra),
    .rdata (mem_q)
  );

  always_ff @(posedge clk) begin
    if (cap_en) begin
      cap_re[cap_idx] <= mem_q[WD-1:DW];
      cap_im[cap_idx] <= mem_q[DW-1:0];
    end
  end

  // first pass rotates output n of butterfly k by W16^(n*k); second pass by W^0
  for (genvar g = 0; g < PTS; g++) begin : g_tw
    assign tw_idx[g] = pass ? '0 : AW'(g * bidx);
  end

  fft4_twiddle #(.TW(TW)) u_tw (
    .clk  (clk),
    .rst  (rst),
    .idx  (tw_idx),
    .w_re (w_re),
    .w_im (w_im)
  );

  fft4_bfly #(.DW(DW), .TW(TW)) u_bf (
    .a_re (cap_re),
    .a_im (cap_im),
    .w_re (w_re),
    .w_im (w_im),
    .y_re (bf_re),
    .y_im (bf_im)
  );

  always_ff @(posedge clk) begin
    if (calc_en) begin
      for (int i = 0; i < PTS; i++) begin
        res_re[i] <= bf_re[i];
        res_im[i] <= bf_im[i];
      end
    end
  end

  assign rd_re = mem_q[WD-1:DW];
  assign rd_im = mem_q[DW-1:0];
endmodule

// File: rtl/fft4_engine_chk.sv
`timescale 1ns/1ps
module fft4_engine_chk #(
  parameter int STEPS = 80
) (
  input logic clk,
  input logic rst,
  input logic ce,
  input logic start,
  input logic busy,
  input logic finish
);
  localparam int CW = $clog2(STEPS + 1) + 1;

  logic [CW-1:0] run_cnt;

  always_ff @(posedge clk) begin
    if (rst || !busy) run_cnt <= '0;
    else if (ce)      run_cnt <= run_cnt + 1'b1;
  end

  // R2
  fin_busy_excl_chk: assert property (@(posedge clk) disable iff (rst)
    finish |-> !busy);

  // R2
  fin_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    finish |=> !finish);

  // R2
  busy_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> finish);

  // R2
  run_len_chk: assert property (@(posedge clk) disable iff (rst)
    finish |-> (run_cnt == CW'(STEPS)));

  // R9
  busy_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> ($past(start) && $past(ce)));

  // R6
  ce_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !ce) |=> (busy && !finish));
endmodule

bind fft4_engine fft4_engine_chk #(.STEPS(fft4_pkg::RUN_STEPS)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .ce     (ce),
  .start  (start),
  .busy   (busy),
  .finish (finish)
);

// File: tb/sim_fft4_engine.sv
`timescale 1ns/1ps
module sim_fft4_engine;

  localparam int  N  = 16;
  localparam real PI = 3.14159265358979;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               ce = 1'b1;
  logic               start = 1'b0;
  logic               busy, finish;
  logic               ld_en = 1'b0;
  logic [3:0]         ld_addr = '0;
  logic signed [15:0] ld_re = '0;
  logic signed [15:0] ld_im = '0;
  logic [3:0]         rd_addr = '0;
  logic signed [15:0] rd_re, rd_im;

  int checks = 0;
  int errors = 0;

  int xr [N];
  int xi [N];
  int exp_re [N];
  int exp_im [N];

  int    q_f[$], q_er[$], q_ei[$], q_tol[$];
  string q_tag[$];
  logic  rd_req = 1'b0;
  logic  req_d = 1'b0;

  fft4_engine u0 (
    .clk(clk), .rst(rst), .ce(ce), .start(start), .busy(busy), .finish(finish),
    .ld_en(ld_en), .ld_addr(ld_addr), .ld_re(ld_re), .ld_im(ld_im),
    .rd_addr(rd_addr), .rd_re(rd_re), .rd_im(rd_im)
  );

  always #5 clk = ~clk;

  task automatic chk(bit ok, string tag, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, act, expv);
    end
  endtask

  // scoreboard monitor: bin requested on one falling edge is checked on the next
  always @(posedge clk) req_d <= rd_req;

  always @(negedge clk) begin
    if (req_d) begin
      int f, er, ei, tol, ar, ai;
      string tg;
      f = q_f.pop_front(); er = q_er.pop_front(); ei = q_ei.pop_front();
      tol = q_tol.pop_front(); tg = q_tag.pop_front();
      ar = int'(rd_re); ai = int'(rd_im);
      checks++;
      if ((ar - er > tol) || (er - ar > tol) || (ai - ei > tol) || (ei - ai > tol)) begin
        errors++;
        $display("FAIL %s: bin %0d got (%0d,%0d) expected (%0d,%0d) tol %0d",
                 tg, f, ar, ai, er, ei, tol);
      end
    end
  end

  task automatic calc_ref();
    for (int f = 0; f < N; f++) begin
      real sr, si, th;
      sr = 0.0; si = 0.0;
      for (int n = 0; n < N; n++) begin
        th = 2.0 * PI * real'(f * n) / real'(N);
        sr = sr + real'(xr[n]) * $cos(th) + real'(xi[n]) * $sin(th);
        si = si + real'(xi[n]) * $cos(th) - real'(xr[n]) * $sin(th);
      end
      exp_re[f] = int'(sr / 16.0);
      exp_im[f] = int'(si / 16.0);
    end
  endtask

  task automatic load_all();
    for (int n = 0; n < N; n++) begin
      @(negedge clk);
      ld_en = 1'b1; ld_addr = 4'(n); ld_re = 16'(xr[n]); ld_im = 16'(xi[n]);
    end
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  // driver: pushes the expected bin and applies its address
  task automatic read_all(int tol, string tag);
    for (int f = 0; f < N; f++) begin
      @(negedge clk);
      rd_addr = 4'(f); rd_req = 1'b1;
      q_f.push_back(f); q_er.push_back(exp_re[f]); q_ei.push_back(exp_im[f]);
      q_tol.push_back(tol); q_tag.push_back(tag);
    end
    @(negedge clk);
    rd_req = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic run_fft(int gap_at, int gap_len, int start_at, int load_at, string tag);
    int c, exp_c;
    exp_c = 81 + gap_len;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    c = 1;
    chk(busy == 1'b1, "R2 busy after start", int'(busy), 1);
    while (!finish && c < 2000) begin
      ce = !(c >= gap_at && c < gap_at + gap_len);
      start = (c == start_at);
      ld_en = (c == load_at);
      ld_addr = 4'd0; ld_re = 16'sh7fff; ld_im = -16'sd32768;
      @(negedge clk);
      c++;
    end
    ce = 1'b1; start = 1'b0; ld_en = 1'b0;
    chk(c == exp_c, tag, c, exp_c);
    chk(busy == 1'b0, "R2 busy low with finish", int'(busy), 0);
    @(negedge clk);
    chk(finish == 1'b0, "R2 finish one cycle", int'(finish), 0);
    chk(busy == 1'b0, "R7 no second run", int'(busy), 0);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL R2: watchdog expired, got no completion expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int unsigned seed;
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R1 busy in reset", int'(busy), 0);
    chk(finish == 1'b0, "R1 finish in reset", int'(finish), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(busy == 1'b0, "R1 busy after reset", int'(busy), 0);
    chk(finish == 1'b0, "R1 finish after reset", int'(finish), 0);

    // R4 constant input
    for (int n = 0; n < N; n++) begin xr[n] = 7000; xi[n] = -3000; end
    load_all(); calc_ref();
    run_fft(0, 0, 0, 0, "R2 run length");
    read_all(0, "R4");

    // R5 impulse
    for (int n = 0; n < N; n++) begin xr[n] = 0; xi[n] = 0; end
    xr[0] = 16000; xi[0] = -8000;
    load_all(); calc_ref();
    run_fft(0, 0, 0, 0, "R2 run length");
    read_all(0, "R5");

    // R3 tone at bin 3, R7 start in the last busy cycle
    for (int n = 0; n < N; n++) begin
      xr[n] = int'(12000.0 * $cos(2.0 * PI * real'(3 * n) / 16.0));
      xi[n] = int'(12000.0 * $sin(2.0 * PI * real'(3 * n) / 16.0));
    end
    load_all(); calc_ref();
    run_fft(0, 0, 80, 0, "R7 run length with late start");
    read_all(4, "R3 tone");

    // R3 random data, R6 ce gap, R8 load while busy, R7 mid-run start
    seed = 32'd12345;
    for (int n = 0; n < N; n++) begin
      seed = seed * 32'd1103515245 + 32'd12345;
      xr[n] = int'((seed >> 16) % 8001) - 4000;
      seed = seed * 32'd1103515245 + 32'd12345;
      xi[n] = int'((seed >> 16) % 8001) - 4000;
    end
    load_all(); calc_ref();
    run_fft(15, 7, 30, 40, "R6 run length with ce gap");
    read_all(4, "R3 R6 R8 random");

    // R9 start while ce low
    @(negedge clk);
    ce = 1'b0; start = 1'b1;
    @(negedge clk);
    ce = 1'b1; start = 1'b0;
    chk(busy == 1'b0, "R9 start with ce low", int'(busy), 0);
    @(negedge clk);
    chk(busy == 1'b0, "R9 still idle", int'(busy), 0);
    read_all(4, "R9 results kept");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule